// File: doc/BRIEF.md
# Bit-Serial Binary-Field Squarer

This block computes the square of an element of GF(2^N) modulo a monic reduction polynomial that is supplied at run time. It is intended as a functional unit inside a point-arithmetic datapath, next to a bit-serial multiplier. Its use is that a squaring finishes in about half the cycles of a general product. Elements are held in polynomial basis: bit i of a vector is the coefficient of x^i. The modulus input carries coefficients p_0 to p_{N-1}. The leading term x^N is implied.

In characteristic 2, squaring spreads coefficient a_i out to position 2i. On an accepted start, the low coefficients a_0..a_{(N-1)/2} already sit below x^N, so they are written straight into the result register. The upper coefficients pass through a separate accumulator, one per cycle, most significant first. Each cycle injects one coefficient at the top position and multiplies the accumulator by x^2. That product needs two chained conditional folds of the modulus within the same clock. The last step merges the accumulator into the result register. N must be odd.

Top module: `gf2n_sq_serial`

## Requirements
- R1: When `done_o` is high, `res_o` equals A*A mod P. Here A is the operand and P = x^N + sum(p_i x^i) is formed from the modulus, both as sampled on the accepted start. Bit i of each vector is the coefficient of x^i.
- R2: Operand and modulus are sampled only in the cycle in which a start is accepted. Changes to `opa_i` and `mod_i` after that cycle do not alter the result of that operation.
- R3: `done_o` is high for exactly one cycle. It rises (N+1)/2 cycles after the cycle in which the start was accepted, whatever the operand and modulus values are.
- R4: `busy_o` is high for exactly (N-1)/2 cycles. These begin in the cycle after an accepted start. `busy_o` and `done_o` are never high together, and `busy_o` stays low while idle with no start.
- R5: A start asserted while `busy_o` is high is ignored. The running operation keeps its operands and its completion cycle.
- R6: `res_o` changes only in a cycle in which `busy_o` or `done_o` is high. After completion it holds its value until the next accepted start.
- R7: While reset is asserted, and after it is released with no start, `busy_o`, `done_o` and `res_o` are all zero.
- R8: A start asserted in the cycle in which `done_o` is high is accepted. Back-to-back operations therefore need no idle cycle between them.
- R9: The result is correct when both bits shifted past x^{N-1} in one step need reduction. This includes moduli with p_{N-1} = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low, released synchronously to the clock |
| start_i | input | 1 | Request a squaring; accepted when `busy_o` is low |
| opa_i | input | N | Operand A, bit i = coefficient of x^i |
| mod_i | input | N | Reduction polynomial coefficients p_0..p_{N-1}; x^N implied |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: `res_o` holds the square |
| res_o | output | N | Result register |

## Verification
The assertions take the start request to be a level that is sampled on each clock edge. They expect the modulus to be any N-bit vector: the datapath reduces by any monic polynomial, so irreducibility is not needed for them to hold. The latency checks also expect reset to be released only between operations or to abort one cleanly. The stimulus keeps to these conditions by changing inputs only on the falling edge. It uses random and directed moduli with the constant term set. It issues starts while idle, while busy and in the done cycle, and it applies reset both while idle and in the middle of an operation.

// File: rtl/gf2n_sq_pkg.sv
package gf2n_sq_pkg;

  // Number of serial fold steps after the load cycle for an odd field size.
  function automatic int sq_half(input int n);
    return (n - 1) / 2;
  endfunction

  // Width of a down-counter able to hold sq_half(n).
  function automatic int sq_cnt_w(input int n);
    return (sq_half(n) < 2) ? 1 : $clog2(sq_half(n) + 1);
  endfunction

endpackage

// File: rtl/gf2n_sq_spread.sv
// Places coefficient c_i[i] at bit 2i of an N-bit vector; odd bits are zero.
module gf2n_sq_spread #(
  parameter int N   = 163,
  parameter int SRC = (N + 1) / 2
) (
  input  logic [SRC-1:0] c_i,
  output logic [N-1:0]   s_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if ((b % 2) == 0 && (b / 2) < SRC) begin : g_even
      assign s_o[b] = c_i[b/2];
    end else begin : g_zero
      assign s_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/gf2n_sq_xpow.sv
// Multiplies v_i by x^SHIFT modulo (x^N + pol_i), one fold stage per position.
module gf2n_sq_xpow #(
  parameter int N     = 163,
  parameter int SHIFT = 2
) (
  input  logic [N-1:0] v_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] v_o
);
  logic [N-1:0] stage [SHIFT+1];

  assign stage[0] = v_i;

  for (genvar k = 0; k < SHIFT; k++) begin : g_fold
    assign stage[k+1] = {stage[k][N-2:0], 1'b0} ^ (stage[k][N-1] ? pol_i : '0);
  end

  assign v_o = stage[SHIFT];
endmodule

// File: rtl/gf2n_sq_ctrl.sv
// Step counter and handshake for the serial squarer.
module gf2n_sq_ctrl
  import gf2n_sq_pkg::*;
#(
  parameter int N = 163
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int H  = sq_half(N);
  localparam int CW = sq_cnt_w(N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  assign busy_o = (cnt_q != '0);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == CW'(1));
  assign done_o = done_q;

  always_comb begin
    cnt_en = load_o || busy_o;
    cnt_d  = cnt_q;
    if (load_o) begin
      cnt_d = CW'(H);
    end else if (busy_o) begin
      cnt_d = cnt_q - CW'(1);
    end
    done_d = last_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/gf2n_sq_serial.sv
// Bit-serial GF(2^N) squarer, N odd. Latency (N+1)/2 cycles from start to done.
module gf2n_sq_serial
  import gf2n_sq_pkg::*;
#(
  parameter int N = 163
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] opa_i,
  input  logic [N-1:0] mod_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] res_o
);
  localparam int H  = sq_half(N);
  localparam int LO = H + 1;

  logic load, step, last;

  logic [H-1:0] hi_q, hi_d;
  logic [N-1:0] acc_q, acc_d;
  logic [N-1:0] res_q, res_d;
  logic [N-1:0] pol_q;
  logic         hi_en, acc_en, res_en, pol_en;

  logic [N-1:0] low_spread;
  logic [N-1:0] inj;
  logic [N-1:0] prod;

  gf2n_sq_ctrl #(.N(N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // Low half lands at even positions below x^N without reduction.
  gf2n_sq_spread #(.N(N), .SRC(LO)) u_spread (
    .c_i (opa_i[H:0]),
    .s_o (low_spread)
  );

  // Next upper coefficient enters at x^(N-1), then the whole value gains x^2.
  assign inj = {acc_q[N-1] ^ hi_q[H-1], acc_q[N-2:0]};

  gf2n_sq_xpow #(.N(N), .SHIFT(2)) u_xpow (
    .v_i   (inj),
    .pol_i (pol_q),
    .v_o   (prod)
  );

  always_comb begin
    pol_en = load;
    hi_en  = load || step;
    acc_en = load || step;
    res_en = load || last;
    hi_d   = load ? opa_i[N-1:H+1] : (hi_q << 1);
    acc_d  = load ? '0 : prod;
    res_d  = load ? low_spread : (prod ^ res_q);
  end

  always_ff @(posedge clk_i) begin
    if (pol_en) begin
      pol_q <= mod_i;
    end
    if (hi_en) begin
      hi_q <= hi_d;
    end
    if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/gf2n_sq_serial_chk.sv
// Protocol and timing checker, bound to every gf2n_sq_serial instance.
module gf2n_sq_serial_chk #(
  parameter int N = 163
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [N-1:0] res_o
);
  localparam int LAT = (N + 1) / 2;

  // Cycles since the last accepted start; zero when no operation is tracked.
  int lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 0;
    end else if (start_i && !busy_o) begin
      lat_q <= 1;
    end else if (done_o) begin
      lat_q <= 0;
    end else if (lat_q != 0 && lat_q < LAT + 4) begin
      lat_q <= lat_q + 1;
    end
  end

  assert_done_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LAT));

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_done_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_idle_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  assert_busy_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && lat_q == LAT - 1) |=> (!busy_o && done_o));

  assert_start_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_res_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> (busy_o || done_o));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R7: assert (!done_o);
    end
  end
endmodule

bind gf2n_sq_serial gf2n_sq_serial_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .res_o   (res_o)
);

// File: tb/sim_gf2n_sq_serial.sv
`timescale 1ns/1ps
module sim_gf2n_sq_serial;
  localparam int NA   = 11;
  localparam int NB   = 3;
  localparam int LATA = (NA + 1) / 2;
  localparam int LATB = (NB + 1) / 2;

  // {operand, modulus, expected} for N=11, P = x^11 + x^2 + 1
  localparam logic [32:0] VEC [7] = '{
    {11'h000, 11'h005, 11'h000},
    {11'h001, 11'h005, 11'h001},
    {11'h002, 11'h005, 11'h004},
    {11'h020, 11'h005, 11'h400},
    {11'h040, 11'h005, 11'h00A},
    {11'h400, 11'h005, 11'h205},
    {11'h7FF, 11'h005, 11'h552}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          st0, busy0, done0;
  logic [NA-1:0] a0, p0, r0;
  logic          st1, busy1, done1;
  logic [NB-1:0] a1, p1, r1;

  int total = 0;
  int fails = 0;
  int cyc   = 0;

  gf2n_sq_serial #(.N(NA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st0), .opa_i(a0), .mod_i(p0),
    .busy_o(busy0), .done_o(done0), .res_o(r0)
  );

  gf2n_sq_serial #(.N(NB)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st1), .opa_i(a1), .mod_i(p1),
    .busy_o(busy1), .done_o(done1), .res_o(r1)
  );

  function automatic logic [31:0] ref_sq(input int n, input logic [31:0] a, input logic [31:0] p);
    logic [63:0] w;
    w = '0;
    for (int i = 0; i < n; i++) if (a[i]) w[2*i] = 1'b1;
    for (int k = 2*n - 2; k >= n; k--)
      if (w[k]) w = w ^ ((({32'b0, p}) | (64'd1 << n)) << (k - n));
    return w[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // One squaring on u0. now=1: start in the current falling-edge slot.
  // garble: disturb inputs after acceptance (R2). restart: start again while busy (R5).
  task automatic run_a(input bit now, input logic [NA-1:0] a, input logic [NA-1:0] p,
                       input bit garble, input bit restart,
                       output logic [NA-1:0] r, output int lat, output int bcnt);
    if (!now) @(negedge clk);
    a0 = a; p0 = p; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0; lat = 1; bcnt = 0;
    if (garble) begin a0 = ~a; p0 = NA'($urandom); end
    if (restart) begin st0 = 1'b1; a0 = NA'($urandom); p0 = ~p; end
    while (!done0 && lat < 40) begin
      if (busy0) bcnt++;
      @(negedge clk);
      st0 = 1'b0;
      lat++;
    end
    r = r0;
  endtask

  task automatic run_b(input logic [NB-1:0] a, input logic [NB-1:0] p,
                       output logic [NB-1:0] r, output int lat);
    @(negedge clk);
    a1 = a; p1 = p; st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0; lat = 1;
    while (!done1 && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    r = r1;
  endtask

  initial begin
    logic [NA-1:0] r, a, p, e;
    logic [NB-1:0] rb;
    int lat, bcnt;

    st0 = 1'b0; a0 = '0; p0 = '0;
    st1 = 1'b0; a1 = '0; p1 = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(!busy0 && !done0 && r0 == '0, "R7 reset outputs", {busy0, done0, r0}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy0 && !done0 && r0 == '0, "R7 idle after reset", {busy0, done0, r0}, 0);
    chk(!busy1 && !done1 && r1 == '0, "R7 idle after reset small", {busy1, done1, r1}, 0);

    // R1: table of hand-derived squares
    for (int v = 0; v < 7; v++) begin
      run_a(1'b0, VEC[v][32:22], VEC[v][21:11], 1'b0, 1'b0, r, lat, bcnt);
      chk(r == VEC[v][10:0], "R1 table square", r, VEC[v][10:0]);
      chk(lat == LATA, "R3 latency", lat, LATA);
      chk(bcnt == LATA - 1, "R4 busy length", bcnt, LATA - 1);
      chk(!busy0, "R4 busy low with done", busy0, 0);
    end

    // R6: result holds after done while idle
    e = r0;
    @(negedge clk);
    chk(!done0, "R3 done single cycle", done0, 0);
    repeat (4) @(negedge clk);
    chk(r0 == e, "R6 result hold", r0, e);

    // R9: moduli with top coefficient set, all-ones operands
    for (int v = 0; v < 4; v++) begin
      a = (v == 0) ? 11'h7FF : NA'($urandom) | 11'h600;
      p = 11'h400 | NA'($urandom) | 11'h001;
      e = ref_sq(NA, a, p);
      run_a(1'b0, a, p, 1'b0, 1'b0, r, lat, bcnt);
      chk(r == e, "R9 double fold", r, e);
    end

    // R1/R2/R5: random operands and moduli, with disturbed inputs and ignored restarts
    for (int v = 0; v < 40; v++) begin
      a = NA'($urandom);
      p = NA'($urandom) | 11'h001;
      e = ref_sq(NA, a, p);
      run_a(1'b0, a, p, v[0], v[1], r, lat, bcnt);
      if (v[1]) begin
        chk(r == e, "R5 restart ignored", r, e);
        chk(lat == LATA, "R5 restart timing", lat, LATA);
      end else if (v[0]) begin
        chk(r == e, "R2 inputs sampled at start", r, e);
      end else begin
        chk(r == e, "R1 random square", r, e);
      end
    end

    // R8: back-to-back start in the done cycle
    a = 11'h3A5; p = 11'h005;
    run_a(1'b0, a, p, 1'b0, 1'b0, r, lat, bcnt);
    for (int v = 0; v < 3; v++) begin
      a = NA'($urandom);
      p = NA'($urandom) | 11'h001;
      e = ref_sq(NA, a, p);
      run_a(1'b1, a, p, 1'b0, 1'b0, r, lat, bcnt);
      chk(r == e, "R8 back-to-back result", r, e);
      chk(lat == LATA, "R8 back-to-back latency", lat, LATA);
    end

    // R1/R3 for the smallest field, exhaustive operands
    for (int m = 1; m < 8; m += 2) begin
      for (int v = 0; v < 8; v++) begin
        run_b(NB'(v), NB'(m), rb, lat);
        chk(rb == NB'(ref_sq(NB, v, m)), "R1 small field", rb, ref_sq(NB, v, m));
        chk(lat == LATB, "R3 small latency", lat, LATB);
      end
    end

    // R7: reset in the middle of an operation
    @(negedge clk);
    a0 = 11'h155; p0 = 11'h005; st0 = 1'b1;
    @(negedge clk);
    st0 = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy0 && !done0 && r0 == '0, "R7 reset aborts", {busy0, done0, r0}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LATA + 2) @(negedge clk);
    chk(!done0 && !busy0 && r0 == '0, "R7 quiet after abort", {busy0, done0, r0}, 0);

    summary();
    $finish;
  end
endmodule